// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a small sum-of-products programmable logic device. It receives eight product terms from the AND array. It ORs them into a sum, which may pass through a flip-flop. It drives a tri-state pad with its own enable, and it returns a feedback signal to the array. Static configuration inputs choose the device-wide mode, the cell's role, its output polarity and its physical position.

The device-wide mode decides how the eight product terms are used: all eight go to the sum, or one of them becomes the output enable and seven go to the sum. The mode also fixes which positions keep pin feedback. A registered cell is clocked by the global clock and enabled by the global output-enable pin. Its register can be preloaded for test. It clears on reset, so its pin reads high afterwards.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst` is high at a clock edge, the register clears to 0, so a registered cell (mode 0, role 0) drives `pad_out` = 1 afterwards.
- R2: A registered cell (mode 0, role 0) captures the OR of all eight `pterm` bits at each rising clock edge. After the edge `pad_out` equals that sum when `pol`=1, and its inverse when `pol`=0. Between edges the value holds.
- R3: In a registered cell, `pad_oe` follows `oe_pin`, and `fb` equals `pad_out` (the inverted register value), whatever `pad_in` is.
- R4: When `preload_en` is high at a clock edge, the register loads `preload_val` instead of the array sum, and a registered cell then drives `pad_out` = NOT `preload_val`. Reset outranks preload.
- R5: In mode 0, a cell with role 1 or 2 (combinatorial) uses `pterm[0]` as `pad_oe` and the OR of `pterm[7:1]` as its sum. `fb` equals `pad_in`.
- R6: In mode 1 (complex), every non-input cell uses `pterm[0]` as `pad_oe` and the OR of `pterm[7:1]` as its sum, whatever the role. Inner cells (`pos` 0) return `pad_in` on `fb`. Outer cells (`pos` 1) return 0.
- R7: In mode 2 or 3 (simple), the sum is the OR of all eight terms and a non-input cell always drives (`pad_oe`=1). Centre cells (`pos` 2 or 3) are always outputs, even with role 3, and return 0 on `fb`. Other positions return `pad_in`.
- R8: A cell with role 3 (dedicated input), except a simple-mode centre cell, holds `pad_oe`=0 and `pad_out`=0 whatever the product terms are. In mode 0 or in inner positions it returns `pad_in` on `fb`.
- R9: For combinatorial cells, `pol`=1 drives the sum on `pad_out` unchanged and `pol`=0 drives its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst | input | 1 | Synchronous clear of the register (models power-up) |
| pterm | input | 8 | Product terms from the AND array |
| oe_pin | input | 1 | Global output enable for registered cells, active high |
| mode | input | 2 | Device mode: 0 registered, 1 complex, 2/3 simple |
| role | input | 2 | Cell role: 0 registered, 1 comb output, 2 comb I/O, 3 input |
| pol | input | 1 | 1 active-high output, 0 active-low |
| pos | input | 2 | Position: 0 inner, 1 outer, 2/3 centre |
| preload_en | input | 1 | Force the register to `preload_val` at the next edge |
| preload_val | input | 1 | Value to preload |
| pad_in | input | 1 | Level present at the pin |
| pad_out | output | 1 | Data driven toward the pin |
| pad_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback to the AND array |

## Verification
The product terms are driven with single-bit patterns on `pterm[0]` and on a high term. This separates an eight-term sum from a seven-term sum with an enable term in each mode. An all-zero pattern and a mixed pattern show the polarity inversion. The register is tested with a preload and a clock edge in the same cycle, which shows which one takes priority. Holding `pterm` changes between edges checks that the output does not move until the next edge. `pad_in` is toggled against each position to tell pin feedback from register feedback and from no feedback.

// File: rtl/pld_macrocell.sv
module pld_macrocell (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pterm,
  input  logic       oe_pin,
  input  logic [1:0] mode,
  input  logic [1:0] role,
  input  logic       pol,
  input  logic [1:0] pos,
  input  logic       preload_en,
  input  logic       preload_val,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       fb
);
  localparam logic [1:0] ModeReg = 2'd0;
  localparam logic [1:0] ModeCpx = 2'd1;
  localparam logic [1:0] RoleReg = 2'd0;
  localparam logic [1:0] RoleIn  = 2'd3;
  localparam logic [1:0] PosOut  = 2'd1;

  logic q;

  wire reg_mode = (mode == ModeReg);
  wire cpx_mode = (mode == ModeCpx);
  wire smp_mode = mode[1];
  wire centre   = pos[1];
  wire outer    = (pos == PosOut);
  wire reg_cell = reg_mode && (role == RoleReg);
  wire in_cell  = (role == RoleIn) && !(smp_mode && centre);
  wire all8     = reg_cell || smp_mode;
  wire sum      = all8 ? |pterm : |pterm[7:1];
  wire lvl      = pol ? sum : ~sum;
  wire no_fb    = (cpx_mode && outer) || (smp_mode && centre);

  always_ff @(posedge clk) begin
    if (rst)             q <= 1'b0;
    else if (preload_en) q <= preload_val;
    else if (reg_cell)   q <= ~lvl;
  end

  assign pad_out = in_cell ? 1'b0 : (reg_cell ? ~q : lvl);
  assign pad_oe  = in_cell ? 1'b0 : (reg_cell ? oe_pin : (smp_mode ? 1'b1 : pterm[0]));
  assign fb      = reg_cell ? ~q : (no_fb ? 1'b0 : pad_in);
endmodule

module pld_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] pterm,
  input logic       oe_pin,
  input logic [1:0] mode,
  input logic [1:0] role,
  input logic       pol,
  input logic [1:0] pos,
  input logic       preload_en,
  input logic       preload_val,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       fb
);
  wire rc = (mode == 2'd0) && (role == 2'd0);

  AST_RESET_HIGH: assert property (@(posedge clk) rst && !preload_en |=> !rc || pad_out); // R1
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rc && !preload_en |=> !rc || (pad_out == ($past(pol) ? $past(|pterm) : !$past(|pterm)))); // R2
  AST_REG_OE: assert property (@(posedge clk) disable iff (rst) rc |-> pad_oe == oe_pin); // R3
  AST_REG_FB: assert property (@(posedge clk) disable iff (rst) rc |-> fb == pad_out); // R3
  AST_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    preload_en |=> !rc || (pad_out == !$past(preload_val))); // R4
  AST_OUTER_NOFB: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) && (pos == 2'd1) |-> !fb); // R6
  AST_CENTRE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    mode[1] && pos[1] |-> pad_oe && !fb); // R7
  AST_INPUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (role == 2'd3) && !(mode[1] && pos[1]) |-> !pad_oe && !pad_out); // R8
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (.*);

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;
  logic clk = 0, rst = 1;
  logic [7:0] pterm = 0;
  logic oe_pin = 0, pol = 1, preload_en = 0, preload_val = 0, pad_in = 0;
  logic [1:0] mode = 0, role = 0, pos = 0;
  logic pad_out, pad_oe, fb;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  pld_macrocell uut (.*);

  task automatic chk(string req, logic got, logic exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic cfg(logic [1:0] m, logic [1:0] r, logic [1:0] p, logic pl);
    @(negedge clk);
    mode = m; role = r; pos = p; pol = pl;
  endtask

  task automatic t_reset();
    cfg(0, 0, 0, 1);
    rst = 1; pterm = 8'h00;
    edge1();
    chk("R1 reset pin high", pad_out, 1'b1);
    @(negedge clk) rst = 0;
  endtask

  task automatic t_reg();
    cfg(0, 0, 0, 1);
    oe_pin = 1; pterm = 8'h80;
    edge1();
    chk("R2 capture high term", pad_out, 1'b1);
    @(negedge clk) pterm = 8'h00; #1;
    chk("R2 hold between edges", pad_out, 1'b1);
    edge1();
    chk("R2 capture zero", pad_out, 1'b0);
    @(negedge clk) pterm = 8'h01; pol = 0;
    edge1();
    chk("R2 active-low capture", pad_out, 1'b0);
    chk("R2 pterm0 counted in sum", pad_out, 1'b0);
    @(negedge clk) pol = 1; pad_in = 1; oe_pin = 0;
    edge1();
    chk("R3 oe follows pin", pad_oe, 1'b0);
    chk("R3 fb from register", fb, 1'b1);
    @(negedge clk) oe_pin = 1; pad_in = 0; #1;
    chk("R3 oe on", pad_oe, 1'b1);
    chk("R3 fb ignores pad", fb, 1'b1);
  endtask

  task automatic t_preload();
    cfg(0, 0, 0, 1);
    pterm = 8'hFF; preload_en = 1; preload_val = 1;
    edge1();
    chk("R4 preload beats clock", pad_out, 1'b0);
    @(negedge clk) preload_val = 0;
    edge1();
    chk("R4 preload low", pad_out, 1'b1);
    @(negedge clk) preload_val = 1; rst = 1;
    edge1();
    chk("R4 reset beats preload", pad_out, 1'b1);
    @(negedge clk) rst = 0; preload_en = 0;
  endtask

  task automatic t_regcomb();
    cfg(0, 1, 0, 1);
    pterm = 8'h01; pad_in = 1; #1;
    chk("R5 oe term", pad_oe, 1'b1);
    chk("R5 pterm0 excluded from sum", pad_out, 1'b0);
    chk("R5 fb from pad", fb, 1'b1);
    pterm = 8'h40; pad_in = 0; #1;
    chk("R5 oe off", pad_oe, 1'b0);
    chk("R5 sum of upper terms", pad_out, 1'b1);
    chk("R5 fb tracks pad", fb, 1'b0);
  endtask

  task automatic t_complex();
    cfg(1, 2, 0, 1);
    pterm = 8'h03; pad_in = 1; #1;
    chk("R6 oe term", pad_oe, 1'b1);
    chk("R6 sum", pad_out, 1'b1);
    chk("R6 inner fb", fb, 1'b1);
    cfg(1, 1, 1, 1);
    pad_in = 1; #1;
    chk("R6 outer no fb", fb, 1'b0);
    cfg(1, 0, 0, 1);
    pterm = 8'h80; #1;
    chk("R6 registered role is comb", pad_oe, 1'b0);
  endtask

  task automatic t_simple();
    cfg(2, 1, 0, 1);
    pterm = 8'h01; pad_in = 1; #1;
    chk("R7 driver on", pad_oe, 1'b1);
    chk("R7 eight-term sum", pad_out, 1'b1);
    chk("R7 pin fb", fb, 1'b1);
    cfg(2, 3, 2, 1);
    pterm = 8'h10; #1;
    chk("R7 centre stays output", pad_oe, 1'b1);
    chk("R7 centre out", pad_out, 1'b1);
    chk("R7 centre no fb", fb, 1'b0);
  endtask

  task automatic t_input();
    cfg(2, 3, 0, 1);
    pterm = 8'hFF; pad_in = 1; #1;
    chk("R8 input oe off", pad_oe, 1'b0);
    chk("R8 input out low", pad_out, 1'b0);
    chk("R8 input fb", fb, 1'b1);
    cfg(0, 3, 0, 0);
    pad_in = 0; #1;
    chk("R8 input oe off reg mode", pad_oe, 1'b0);
    chk("R8 fb reg mode", fb, 1'b0);
  endtask

  task automatic t_pol();
    cfg(2, 1, 0, 0);
    pterm = 8'h00; #1;
    chk("R9 active-low of zero", pad_out, 1'b1);
    pterm = 8'h24; #1;
    chk("R9 active-low of one", pad_out, 1'b0);
    pol = 1; #1;
    chk("R9 active-high", pad_out, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_reg(); t_preload(); t_regcomb();
        t_complex(); t_simple(); t_input(); t_pol();
      end
      begin
        repeat (5000) @(posedge clk);
        runs++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule